// File: doc/BRIEF.md
# Bus Master Security Filter

This block sits on the path from a single bus master to a downstream memory port. For every read or write it decides whether the access may go through, and with which security attribute. The decision uses three inputs. The first is a per-address attribution result from an external lookup unit, which reports whether the address is exempt from checking, lies in a non-secure region, or is callable from non-secure code. The second is a level that configures the master as secure or non-secure. The third is a level that selects how blocked accesses respond.

An access that is allowed is issued downstream as one request, tagged with a secure flag. The downstream response comes back to the master unchanged. An access that is blocked never reaches the downstream port and is answered in the next cycle. In quiet mode it completes as read-as-zero / write-ignored. In error mode it returns an error and raises a sticky interrupt. A level clear input removes that interrupt and holds it off for as long as it stays high.

Both request channels use valid/ready. A request transfers on a cycle where valid and ready are both high. Once valid is raised it holds steady, with its fields unchanged, until ready is seen. The filter allows one access outstanding. Upstream ready is low from acceptance until the response handshake. The response is held with its data stable while `up_rsp_ready` is low. The downstream response is a single-cycle `dn_rsp_valid` pulse with no ready, and it is accepted only after the downstream request handshake.

Top module: `bus_sec_filter`

## Requirements
- R1: When the lookup reports the address as exempt, the access is issued downstream with `dn_req_secure` = 1 if `cfg_master_ns` is 0, and `dn_req_secure` = 0 if it is 1. This holds whatever `lk_ns` reports.
- R2: When the address is not exempt and `lk_ns` is 1, the access is issued downstream with `dn_req_secure` = 0, for either master setting.
- R3: When the address is neither exempt nor non-secure and `cfg_master_ns` is 0, the access is issued downstream with `dn_req_secure` = 1.
- R4: When the address is neither exempt nor non-secure and `cfg_master_ns` is 1, the access is blocked: `dn_req_valid` stays low for it and the downstream contents are unchanged.
- R5: A blocked access with `cfg_abort_mode` = 0 raises `up_rsp_valid` in the cycle after acceptance, with `up_rsp_err` = 0 and `up_rsp_rdata` = 0.
- R6: A blocked access with `cfg_abort_mode` = 1 responds in the cycle after acceptance with `up_rsp_err` = 1. If `irq_clr` is low, `irq` goes high in that same cycle and stays high.
- R7: While `irq_clr` is high, `irq` is low in the same cycle, and no blocked access sets it. The status is cleared, so `irq` stays low after `irq_clr` falls.
- R8: During and right after reset, `irq`, `up_rsp_valid` and `dn_req_valid` are 0 and `up_req_ready` is 1.
- R9: An allowed access is issued with the request's address, write flag, size code and write data unchanged. The `size` code 0/1/2/3 means 1/2/4/8 bytes, right-justified in the data, little-endian. `dn_rsp_rdata` and `dn_rsp_err` are returned to the master unchanged.
- R10: `lk_nsc` has no effect on any output.
- R11: While `dn_req_valid` is high and `dn_req_ready` is low, the request stays valid and its fields, including `dn_req_secure`, stay stable.
- R12: `up_req_ready` is low while an access is outstanding. A response held back by `up_rsp_ready` = 0 keeps its data and error bit stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_master_ns | input | 1 | Master is non-secure when 1 |
| cfg_abort_mode | input | 1 | Blocked accesses give an error (1) or read-as-zero/write-ignored (0) |
| irq_clr | input | 1 | Level: clears and suppresses the interrupt |
| irq | output | 1 | Level interrupt for error-mode blocked accesses |
| up_req_valid | input | 1 | Master request valid |
| up_req_ready | output | 1 | Filter accepts a request |
| up_req_addr | input | ADDR_W | Request address |
| up_req_write | input | 1 | 1 = write |
| up_req_size | input | 2 | Size code (log2 bytes) |
| up_req_wdata | input | DATA_W | Write data, right-justified |
| up_rsp_valid | output | 1 | Response valid |
| up_rsp_ready | input | 1 | Master accepts the response |
| up_rsp_rdata | output | DATA_W | Read data |
| up_rsp_err | output | 1 | Error response |
| lk_addr | output | ADDR_W | Address presented to the attribution lookup |
| lk_exempt | input | 1 | Lookup: address exempt from checking |
| lk_ns | input | 1 | Lookup: non-secure region |
| lk_nsc | input | 1 | Lookup: non-secure-callable (ignored) |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream accepts the request |
| dn_req_addr | output | ADDR_W | Downstream address |
| dn_req_write | output | 1 | Downstream write flag |
| dn_req_size | output | 2 | Downstream size code |
| dn_req_wdata | output | DATA_W | Downstream write data |
| dn_req_secure | output | 1 | Security attribute of the downstream request |
| dn_rsp_valid | input | 1 | Downstream response pulse |
| dn_rsp_rdata | input | DATA_W | Downstream read data |
| dn_rsp_err | input | 1 | Downstream error |

## Verification
A latched verdict that is wrong shows up on the first downstream request of that access, as a flipped `dn_req_secure`. For a block it shows up one cycle after acceptance, as a request that leaks downstream or as a response that arrives late. A leaked write then corrupts a later read, which the bench compares against its own reference memory. A stuck or lost interrupt status is visible on `irq` one cycle after the triggering acceptance. A clear that acts late is visible within the same cycle, because the bench samples `irq` 1 ns after it raises `irq_clr`.

// File: rtl/bsf_pkg.sv
package bsf_pkg;
  typedef enum logic [1:0] {
    VD_ABORT   = 2'd0,
    VD_RAZWI   = 2'd1,
    VD_PASS_S  = 2'd2,
    VD_PASS_NS = 2'd3
  } verdict_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } state_e;
endpackage

// File: rtl/bsf_decide.sv
module bsf_decide
  import bsf_pkg::*;
(
  input  logic     exempt,
  input  logic     ns_region,
  input  logic     master_ns,
  input  logic     abort_mode,
  output verdict_e verdict
);
  always_comb begin
    if (exempt)          verdict = master_ns ? VD_PASS_NS : VD_PASS_S;
    else if (ns_region)  verdict = VD_PASS_NS;
    else if (!master_ns) verdict = VD_PASS_S;
    else                 verdict = abort_mode ? VD_ABORT : VD_RAZWI;
  end
endmodule

// File: rtl/bsf_irq.sv
module bsf_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_lvl,
  output logic irq
);
  logic stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= 1'b0;
    else if (clr_lvl) stat_q <= 1'b0;
    else if (set_evt) stat_q <= 1'b1;
  end

  // clear acts in the same cycle on the output
  assign irq = stat_q & ~clr_lvl;
endmodule

// File: rtl/bus_sec_filter.sv
module bus_sec_filter
  import bsf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_master_ns,
  input  logic              cfg_abort_mode,
  input  logic              irq_clr,
  output logic              irq,
  input  logic              up_req_valid,
  output logic              up_req_ready,
  input  logic [ADDR_W-1:0] up_req_addr,
  input  logic              up_req_write,
  input  logic [1:0]        up_req_size,
  input  logic [DATA_W-1:0] up_req_wdata,
  output logic              up_rsp_valid,
  input  logic              up_rsp_ready,
  output logic [DATA_W-1:0] up_rsp_rdata,
  output logic              up_rsp_err,
  output logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_exempt,
  input  logic              lk_ns,
  input  logic              lk_nsc,
  output logic              dn_req_valid,
  input  logic              dn_req_ready,
  output logic [ADDR_W-1:0] dn_req_addr,
  output logic              dn_req_write,
  output logic [1:0]        dn_req_size,
  output logic [DATA_W-1:0] dn_req_wdata,
  output logic              dn_req_secure,
  input  logic              dn_rsp_valid,
  input  logic [DATA_W-1:0] dn_rsp_rdata,
  input  logic              dn_rsp_err
);
  localparam int BYTES = DATA_W / 8;

  state_e            state_q;
  verdict_e          verdict;
  logic              accept;
  logic              blocked;
  logic [ADDR_W-1:0] addr_q;
  logic              write_q;
  logic [1:0]        size_q;
  logic [DATA_W-1:0] wdata_q;
  logic              sec_q;
  logic [DATA_W-1:0] rdata_q;
  logic              err_q;
  logic              unused_nsc;

  // the callable attribute plays no part in the verdict
  assign unused_nsc = lk_nsc;

  initial begin
    if (BYTES != 8 && BYTES != 4) $error("DATA_W must be 32 or 64");
  end

  assign lk_addr = up_req_addr;

  bsf_decide u_decide (
    .exempt     (lk_exempt),
    .ns_region  (lk_ns),
    .master_ns  (cfg_master_ns),
    .abort_mode (cfg_abort_mode),
    .verdict    (verdict)
  );

  assign up_req_ready = (state_q == ST_IDLE);
  assign accept       = up_req_valid && up_req_ready;
  assign blocked      = (verdict == VD_ABORT) || (verdict == VD_RAZWI);

  bsf_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (accept && (verdict == VD_ABORT)),
    .clr_lvl (irq_clr),
    .irq     (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      write_q <= 1'b0;
      size_q  <= '0;
      wdata_q <= '0;
      sec_q   <= 1'b0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          addr_q  <= up_req_addr;
          write_q <= up_req_write;
          size_q  <= up_req_size;
          wdata_q <= up_req_wdata;
          sec_q   <= (verdict == VD_PASS_S);
          if (blocked) begin
            rdata_q <= '0;
            err_q   <= (verdict == VD_ABORT);
            state_q <= ST_RESP;
          end else begin
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (dn_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (dn_rsp_valid) begin
          rdata_q <= dn_rsp_rdata;
          err_q   <= dn_rsp_err;
          state_q <= ST_RESP;
        end
        ST_RESP: if (up_rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dn_req_valid  = (state_q == ST_ISSUE);
  assign dn_req_addr   = addr_q;
  assign dn_req_write  = write_q;
  assign dn_req_size   = size_q;
  assign dn_req_wdata  = wdata_q;
  assign dn_req_secure = sec_q;

  assign up_rsp_valid = (state_q == ST_RESP);
  assign up_rsp_rdata = rdata_q;
  assign up_rsp_err   = err_q;
endmodule

// File: rtl/bsf_checker.sv
module bsf_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_master_ns,
  input logic              cfg_abort_mode,
  input logic              irq_clr,
  input logic              irq,
  input logic              up_req_valid,
  input logic              up_req_ready,
  input logic              up_rsp_valid,
  input logic              up_rsp_ready,
  input logic [DATA_W-1:0] up_rsp_rdata,
  input logic              up_rsp_err,
  input logic              lk_exempt,
  input logic              lk_ns,
  input logic              dn_req_valid,
  input logic              dn_req_ready,
  input logic [ADDR_W-1:0] dn_req_addr,
  input logic              dn_req_write,
  input logic [1:0]        dn_req_size,
  input logic [DATA_W-1:0] dn_req_wdata,
  input logic              dn_req_secure
);
  logic acc, sec_hit_ns;
  assign acc        = up_req_valid && up_req_ready;
  assign sec_hit_ns = !lk_exempt && !lk_ns && cfg_master_ns;

  AST_NS_REGION_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !lk_exempt && lk_ns |=> dn_req_valid && !dn_req_secure); // R2

  AST_BLOCK_NO_DN: assert property (@(posedge clk) disable iff (!rst_n)
    acc && sec_hit_ns |=> up_rsp_valid && !dn_req_valid); // R4

  AST_RAZ_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    acc && sec_hit_ns && !cfg_abort_mode |=> up_rsp_rdata == '0 && !up_rsp_err); // R5

  AST_ABORT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    acc && sec_hit_ns && cfg_abort_mode && !irq_clr |=> up_rsp_err && (irq || irq_clr)); // R6

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |-> !irq); // R7

  AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid && !dn_req_ready |=> dn_req_valid && $stable(dn_req_addr)
      && $stable(dn_req_write) && $stable(dn_req_size)
      && $stable(dn_req_wdata) && $stable(dn_req_secure)); // R11

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    up_rsp_valid && !up_rsp_ready |=> up_rsp_valid && $stable(up_rsp_rdata)
      && $stable(up_rsp_err)); // R12

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rsp_valid || dn_req_valid) |-> !up_req_ready); // R12
endmodule

bind bus_sec_filter bsf_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_master_ns  (cfg_master_ns),
  .cfg_abort_mode (cfg_abort_mode),
  .irq_clr        (irq_clr),
  .irq            (irq),
  .up_req_valid   (up_req_valid),
  .up_req_ready   (up_req_ready),
  .up_rsp_valid   (up_rsp_valid),
  .up_rsp_ready   (up_rsp_ready),
  .up_rsp_rdata   (up_rsp_rdata),
  .up_rsp_err     (up_rsp_err),
  .lk_exempt      (lk_exempt),
  .lk_ns          (lk_ns),
  .dn_req_valid   (dn_req_valid),
  .dn_req_ready   (dn_req_ready),
  .dn_req_addr    (dn_req_addr),
  .dn_req_write   (dn_req_write),
  .dn_req_size    (dn_req_size),
  .dn_req_wdata   (dn_req_wdata),
  .dn_req_secure  (dn_req_secure)
);

// File: tb/bus_sec_filter_test.sv
`timescale 1ns/1ps
module bus_sec_filter_test;
  localparam int AW = 32;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_master_ns = 1'b0, cfg_abort_mode = 1'b0, irq_clr = 1'b0;
  logic irq;
  logic up_req_valid = 1'b0, up_req_ready;
  logic [AW-1:0] up_req_addr = '0;
  logic up_req_write = 1'b0;
  logic [1:0] up_req_size = '0;
  logic [DW-1:0] up_req_wdata = '0;
  logic up_rsp_valid, up_rsp_ready = 1'b0;
  logic [DW-1:0] up_rsp_rdata;
  logic up_rsp_err;
  logic [AW-1:0] lk_addr;
  logic lk_exempt, lk_ns, lk_nsc;
  logic nsc_val = 1'b0;
  logic dn_req_valid, dn_req_ready = 1'b0;
  logic [AW-1:0] dn_req_addr;
  logic dn_req_write;
  logic [1:0] dn_req_size;
  logic [DW-1:0] dn_req_wdata;
  logic dn_req_secure;
  logic dn_rsp_valid = 1'b0;
  logic [DW-1:0] dn_rsp_rdata = '0;
  logic dn_rsp_err = 1'b0;

  int checks = 0, errors = 0;

  always #4 clk = ~clk; // 125 MHz

  // attribution model: addr[7:6] region 0 exempt, 1 non-secure, 2/3 secure
  assign lk_exempt = (lk_addr[7:6] == 2'd0);
  assign lk_ns     = (lk_addr[7:6] == 2'd1) || (lk_addr[7:6] == 2'd0 && lk_addr[5]);
  assign lk_nsc    = nsc_val;

  bus_sec_filter #(.ADDR_W(AW), .DATA_W(DW)) uut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] le_merge(input logic [63:0] w, input int off,
                                           input logic [1:0] sz, input logic [63:0] d);
    for (int b = 0; b < 8; b++)
      if (b >= off && b < off + (1 << sz)) w[b*8 +: 8] = d[(b-off)*8 +: 8];
    return w;
  endfunction

  function automatic logic [63:0] le_pick(input logic [63:0] w, input int off, input logic [1:0] sz);
    logic [63:0] r = '0;
    for (int b = 0; b < (1 << sz); b++) r[b*8 +: 8] = w[(off+b)*8 +: 8];
    return r;
  endfunction

  // downstream memory model, mem index = addr[7:3], addr[8] = error region
  logic [63:0] mem [0:31];
  logic [63:0] ref_mem [0:31];
  int dn_count = 0;
  logic [AW-1:0] last_addr; logic last_wr; logic [1:0] last_sz;
  logic [63:0] last_wd; logic last_sec;
  logic pv = 1'b0, pr = 1'b0;
  logic [AW-1:0] pa; logic pw; logic [1:0] ps; logic [63:0] pd; logic psec;
  int pend = 0; logic [63:0] pend_d; logic pend_e;

  initial begin
    for (int i = 0; i < 32; i++) begin
      mem[i] = {32'hC0DE_0000 + i, 32'h1357_0000 + i * 3};
      ref_mem[i] = mem[i];
    end
    forever begin
      @(negedge clk);
      dn_rsp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          dn_rsp_valid = 1'b1; dn_rsp_rdata = pend_d; dn_rsp_err = pend_e;
        end
      end
      if (pv && pr) begin
        dn_count++;
        last_addr = pa; last_wr = pw; last_sz = ps; last_wd = pd; last_sec = psec;
        pend_e = pa[8];
        pend_d = pw ? 64'hDEAD_BEEF_0BAD_F00D : le_pick(mem[pa[7:3]], int'(pa[2:0]), ps);
        if (pw && !pa[8]) mem[pa[7:3]] = le_merge(mem[pa[7:3]], int'(pa[2:0]), ps, pd);
        pend = 1 + int'($urandom % 3);
      end else if (pv && !pr && dn_req_valid) begin
        check("R11 held request", {dn_req_addr[31:0], 27'd0, dn_req_write, dn_req_size, dn_req_secure},
              {pa[31:0], 27'd0, pw, ps, psec});
        check("R11 held wdata", dn_req_wdata, pd);
      end
      pv = dn_req_valid; pa = dn_req_addr; pw = dn_req_write; ps = dn_req_size;
      pd = dn_req_wdata; psec = dn_req_secure;
      dn_req_ready = ($urandom % 3) != 0;
      pr = dn_req_ready;
    end
  end

  logic irq_m = 1'b0;

  task automatic do_access(input logic [8:0] a_in, input logic wr, input logic [1:0] sz,
                           input logic [63:0] wd, input logic mns, input logic abm,
                           input logic clr, input logic nsc);
    logic [8:0] a;
    logic ex, ns, blk, sec_exp;
    int n0, cyc, first, stalls, off;
    logic got;
    logic [63:0] rd, sz_mask;
    logic er;
    string rq;
    a = a_in & ~9'((1 << sz) - 1);
    off = int'(a[2:0]);
    ex = (a[7:6] == 2'd0);
    ns = (a[7:6] == 2'd1);
    blk = !ex && !ns && mns;
    sec_exp = ex ? !mns : (ns ? 1'b0 : 1'b1);
    rq = ex ? "R1" : (ns ? "R2" : "R3");
    sz_mask = '0;
    @(negedge clk);
    up_req_addr = {23'd0, a}; up_req_write = wr; up_req_size = sz; up_req_wdata = wd;
    cfg_master_ns = mns; cfg_abort_mode = abm; irq_clr = clr; nsc_val = nsc;
    up_req_valid = 1'b1;
    check("R12 ready when idle", up_req_ready, 1'b1);
    n0 = dn_count;
    @(posedge clk);
    cyc = 0; got = 1'b0; stalls = 0; first = 0; rd = '0; er = 1'b0;
    forever begin
      @(negedge clk);
      up_req_valid = 1'b0;
      cyc++;
      if (cyc > 60) begin check("R12 response timeout", 1'b0, 1'b1); break; end
      if (up_rsp_valid) begin
        if (!got) begin got = 1'b1; first = cyc; rd = up_rsp_rdata; er = up_rsp_err; end
        else begin
          check("R12 held rdata", up_rsp_rdata, rd);
          check("R12 held err", up_rsp_err, er);
        end
        check("R12 busy while outstanding", up_req_ready, 1'b0);
        if (stalls < 2 && ($urandom % 2) == 1) begin
          up_rsp_ready = 1'b0; stalls++;
        end else begin
          up_rsp_ready = 1'b1; @(posedge clk); break;
        end
      end else up_rsp_ready = 1'b0;
    end
    #1 up_rsp_ready = 1'b0;
    if (blk) begin
      check("R4 no downstream request", dn_count, n0);
      check(abm ? "R6 next-cycle response" : "R5 next-cycle response", first, 1);
      check(abm ? "R6 error bit" : "R5 error bit", er, abm);
      if (!abm) check("R5 zero data", rd, 64'd0);
    end else begin
      check({rq, " one downstream request"}, dn_count, n0 + 1);
      check({rq, " secure attribute"}, last_sec, sec_exp);
      check("R9 address", last_addr, {23'd0, a});
      check("R9 write flag and size", {last_wr, last_sz}, {wr, sz});
      if (wr) check("R9 write data", last_wd, wd);
      check("R9 error passthrough", er, a[8]);
      if (!wr) check("R9 read data", rd, le_pick(ref_mem[a[7:3]], off, sz));
      if (wr && !a[8]) ref_mem[a[7:3]] = le_merge(ref_mem[a[7:3]], off, sz, wd);
    end
    if (clr) irq_m = 1'b0;
    else if (blk && abm) irq_m = 1'b1;
    @(negedge clk);
    check(clr ? "R7 irq held low" : "R6 irq level", irq, irq_m && !clr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check("R8 irq in reset", irq, 1'b0);
    check("R8 rsp valid in reset", up_rsp_valid, 1'b0);
    check("R8 dn valid in reset", dn_req_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 ready after reset", up_req_ready, 1'b1);
    check("R8 irq after reset", irq, 1'b0);

    // R1: exempt, secure master then non-secure master; addr[5] sets lk_ns too
    do_access(9'h028, 1'b1, 2'd3, 64'h0102_0304_0506_0708, 1'b0, 1'b0, 1'b0, 1'b0);
    do_access(9'h028, 1'b0, 2'd3, 64'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    // R2: non-secure region, both masters
    do_access(9'h048, 1'b1, 2'd2, 64'h0000_0000_AABB_CCDD, 1'b0, 1'b0, 1'b0, 1'b0);
    do_access(9'h04C, 1'b0, 2'd1, 64'd0, 1'b1, 1'b0, 1'b0, 1'b1);
    // R3 + R9: secure write byte, then read back word
    do_access(9'h093, 1'b1, 2'd0, 64'h0000_0000_0000_00E7, 1'b0, 1'b0, 1'b0, 1'b0);
    do_access(9'h090, 1'b0, 2'd2, 64'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R4/R5: blocked write in quiet mode leaves memory unchanged
    do_access(9'h0D0, 1'b1, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b0);
    do_access(9'h0D0, 1'b0, 2'd3, 64'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    do_access(9'h0D0, 1'b0, 2'd3, 64'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    // R10: callable flag set on a blocked and an allowed access
    do_access(9'h0C8, 1'b0, 2'd3, 64'd0, 1'b1, 1'b0, 1'b0, 1'b1);
    do_access(9'h0C8, 1'b0, 2'd3, 64'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    // R6: error-mode block raises irq
    do_access(9'h0E0, 1'b0, 2'd2, 64'd0, 1'b1, 1'b1, 1'b0, 1'b0);
    // R7: clear acts in the same cycle and the status stays cleared
    @(negedge clk); irq_clr = 1'b1; #1;
    check("R7 immediate clear", irq, 1'b0);
    @(negedge clk); irq_clr = 1'b0; #1;
    check("R7 stays cleared", irq, 1'b0);
    irq_m = 1'b0;
    // R7: error-mode block with clear held does not set irq
    do_access(9'h0E0, 1'b1, 2'd2, 64'h55, 1'b1, 1'b1, 1'b1, 1'b0);
    @(negedge clk); irq_clr = 1'b0; #1;
    check("R7 suppressed status", irq, 1'b0);
    // R9: downstream error region
    do_access(9'h188, 1'b0, 2'd3, 64'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    do_access(9'h148, 1'b1, 2'd3, 64'h77, 1'b1, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < 400; i++) begin
      do_access(9'($urandom), 1'($urandom), 2'($urandom), {$urandom, $urandom},
                1'($urandom), 1'($urandom), ($urandom % 4) == 0, 1'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule